// File: doc/BRIEF.md
# Low-Power Core Clock Pacer with Automatic Return to Full Speed

This block paces the processor core by driving a clock-enable line that sits next to the free-running input clock. At full speed the enable is held high, so the core advances on every edge. When software selects the slow mode, the enable becomes a one-cycle pulse once every 256 input clocks. The core then runs at 1/256 of its normal rate and stays fully static between pulses.

A second control bit arms a switchback mechanism. While it is armed, certain hardware events drop the block out of slow mode on their own, so the system can burst back to full rate without waiting for software. The qualifying events are:
- an external interrupt line (0 or 1) that was both enabled and acknowledged;
- a detected serial start bit;
- a load of the serial transmit buffer;
- a reset request.

After a switchback the block stays at full speed until software writes the slow-mode bit again. Software writes each control bit through its own strobe and value pair. A reset request clears both bits whatever they held.

Top module: `pwr_clk_pacer`

## Requirements
- R1: Out of reset `slow_mode` is 0 and `clk_en` is 1, and the switchback arm bit is cleared.
- R2: A cycle with `slow_wr`=1 and `slow_val`=1 sets `slow_mode` to 1 from the next cycle, unless R5, R9 or R10 overrides it.
- R3: In slow mode `clk_en` is a single-cycle pulse that repeats every 256 clocks. The pacing count restarts from zero when the mode changes, so the first pulse is in the 256th cycle in which `slow_mode` reads 1.
- R4: A write with `slow_val`=0 returns the block to full speed from the next cycle, and `clk_en` is then 1 in every cycle.
- R5: When switchback is armed (`swb_val`=1 written through `swb_wr`), a qualifying event in slow mode clears `slow_mode` in the next cycle. Qualifying events are `ser_start`, `tx_load`, or bit i of `irq_ack` together with bit i of `irq_en`.
- R6: An interrupt line qualifies only when its `irq_ack` bit and its `irq_en` bit are both 1 in the same cycle. An acknowledge without the enable, an enable without the acknowledge, or an acknowledge on one line with the enable on the other leaves slow mode unchanged.
- R7: With switchback disarmed, events leave `slow_mode` unchanged.
- R8: After a switchback the block stays at full speed, whatever events follow, until a fresh slow-mode write. The arm bit stays set, so a later entry can switch back again.
- R9: A `rst_evt` pulse forces full speed and disarms switchback. A following slow-mode entry then ignores events.
- R10: When a qualifying event meets a slow-mode write in the same cycle while switchback is armed, the event wins and the block stays at full speed.
- R11: A slow-mode write while already in slow mode does not restart the pacing count; the pulse phase is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_evt | input | 1 | Reset request pulse: forces full speed and disarms switchback |
| slow_wr | input | 1 | Write strobe for the slow-mode bit |
| slow_val | input | 1 | Value written to the slow-mode bit (1 = divide by 256) |
| swb_wr | input | 1 | Write strobe for the switchback arm bit |
| swb_val | input | 1 | Value written to the switchback arm bit |
| irq_ack | input | NUM_IRQ | Per-line external interrupt acknowledge pulse |
| irq_en | input | NUM_IRQ | Per-line external interrupt enable level |
| ser_start | input | 1 | Serial receiver detected a start bit |
| tx_load | input | 1 | Serial transmit buffer was loaded |
| clk_en | output | 1 | Core clock enable |
| slow_mode | output | 1 | 1 while the divide-by-256 mode is active |

## Verification
The hardest states to reach from the ports depend on exact alignment within one clock. One is a slow-mode write that lands on the same edge as a qualifying event. The other is a rewrite of slow mode partway through the 256-cycle pacing window. The directed tasks drive all strobes together on one falling edge, so they meet the same rising edge. The pacing tasks step through every cycle of the window and record where each pulse falls, which shows whether the count phase was kept or restarted. Whether switchback is disarmed after a reset request cannot be read at any port. It is shown by re-entering slow mode and firing an event that would otherwise have switched the block back.

// File: rtl/pm_clk_pkg.sv
package pm_clk_pkg;

  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_SLOW = 1'b1
  } pm_mode_e;

endpackage

// File: rtl/pm_evt_qual.sv
module pm_evt_qual #(
  parameter int NUM_IRQ = 2
) (
  input  logic [NUM_IRQ-1:0] irq_ack,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               ser_start,
  input  logic               tx_load,
  output logic               evt_any
);

  logic [NUM_IRQ-1:0] irq_hit;

  // An interrupt line counts only when it was enabled and acknowledged.
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    assign irq_hit[g] = irq_ack[g] & irq_en[g];
  end

  assign evt_any = (|irq_hit) | ser_start | tx_load;

endmodule

// File: rtl/pm_mode_ctl.sv
module pm_mode_ctl
  import pm_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rst_evt,
  input  logic     slow_wr,
  input  logic     slow_val,
  input  logic     swb_wr,
  input  logic     swb_val,
  input  logic     evt_any,
  output pm_mode_e mode,
  output logic     swb_en,
  output logic     mode_chg
);

  pm_mode_e mode_q, mode_d;
  logic     swb_q, swb_d;

  // Priority, lowest first: software write, switchback, reset request.
  always_comb begin
    mode_d = mode_q;
    swb_d  = swb_q;
    if (swb_wr)  swb_d  = swb_val;
    if (slow_wr) mode_d = slow_val ? MODE_SLOW : MODE_FULL;
    if (swb_q && evt_any) mode_d = MODE_FULL;
    if (rst_evt) begin
      mode_d = MODE_FULL;
      swb_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FULL;
      swb_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      swb_q  <= swb_d;
    end
  end

  assign mode     = mode_q;
  assign swb_en   = swb_q;
  assign mode_chg = (mode_d != mode_q);

endmodule

// File: rtl/pm_pace_cnt.sv
module pm_pace_cnt #(
  parameter int DIV_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);

  localparam logic [DIV_LOG2-1:0] CNT_TOP = {DIV_LOG2{1'b1}};
  localparam logic [DIV_LOG2-1:0] CNT_ONE = {{(DIV_LOG2-1){1'b0}}, 1'b1};

  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + CNT_ONE;
  end

  assign tick = run & (cnt_q == CNT_TOP);

endmodule

// File: rtl/pwr_clk_pacer.sv
module pwr_clk_pacer
  import pm_clk_pkg::*;
#(
  parameter int NUM_IRQ  = 2,
  parameter int DIV_LOG2 = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_evt,
  input  logic               slow_wr,
  input  logic               slow_val,
  input  logic               swb_wr,
  input  logic               swb_val,
  input  logic [NUM_IRQ-1:0] irq_ack,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               ser_start,
  input  logic               tx_load,
  output logic               clk_en,
  output logic               slow_mode
);

  pm_mode_e mode;
  logic     evt_any;
  logic     swb_en_q;
  logic     mode_chg;
  logic     pace_tick;

  pm_evt_qual #(.NUM_IRQ(NUM_IRQ)) u_qual (
    .irq_ack   (irq_ack),
    .irq_en    (irq_en),
    .ser_start (ser_start),
    .tx_load   (tx_load),
    .evt_any   (evt_any)
  );

  pm_mode_ctl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_evt  (rst_evt),
    .slow_wr  (slow_wr),
    .slow_val (slow_val),
    .swb_wr   (swb_wr),
    .swb_val  (swb_val),
    .evt_any  (evt_any),
    .mode     (mode),
    .swb_en   (swb_en_q),
    .mode_chg (mode_chg)
  );

  pm_pace_cnt #(.DIV_LOG2(DIV_LOG2)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mode_chg),
    .run   (mode == MODE_SLOW),
    .tick  (pace_tick)
  );

  assign slow_mode = (mode == MODE_SLOW);
  assign clk_en    = (mode == MODE_FULL) | pace_tick;

endmodule

// File: rtl/pwr_clk_pacer_chk.sv
module pwr_clk_pacer_chk #(
  parameter int NUM_IRQ = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_evt,
  input logic               slow_wr,
  input logic               slow_val,
  input logic [NUM_IRQ-1:0] irq_ack,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic               ser_start,
  input logic               tx_load,
  input logic               clk_en,
  input logic               slow_mode,
  input logic               swb_en
);

  logic ev_seen;
  assign ev_seen = (|(irq_ack & irq_en)) | ser_start | tx_load;

  // R9: a reset request always lands in full speed
  p_rst_evt_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> !slow_mode);

  // R2: an uncontested slow write takes effect next cycle
  p_slow_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_wr && slow_val && !rst_evt && !(swb_en && ev_seen)) |=> slow_mode);

  // R3: slow pulses last one cycle
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_mode && clk_en) |=> (!slow_mode || !clk_en));

  // R4: full speed means enable every cycle
  p_full_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_mode |-> clk_en);

  // R5: armed switchback exits slow mode
  p_switchback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_mode && swb_en && ev_seen) |=> !slow_mode);

  // R7: disarmed switchback holds slow mode
  p_no_switchback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_mode && !swb_en && !slow_wr && !rst_evt) |=> slow_mode);

  // R8: full speed persists without a slow write
  p_stay_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_mode && !(slow_wr && slow_val)) |=> !slow_mode);

endmodule

bind pwr_clk_pacer pwr_clk_pacer_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_evt   (rst_evt),
  .slow_wr   (slow_wr),
  .slow_val  (slow_val),
  .irq_ack   (irq_ack),
  .irq_en    (irq_en),
  .ser_start (ser_start),
  .tx_load   (tx_load),
  .clk_en    (clk_en),
  .slow_mode (slow_mode),
  .swb_en    (swb_en_q)
);

// File: tb/pwr_clk_pacer_test.sv
module pwr_clk_pacer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_evt = 1'b0;
  logic       slow_wr = 1'b0;
  logic       slow_val = 1'b0;
  logic       swb_wr = 1'b0;
  logic       swb_val = 1'b0;
  logic [1:0] irq_ack = 2'b00;
  logic [1:0] irq_en = 2'b00;
  logic       ser_start = 1'b0;
  logic       tx_load = 1'b0;
  logic       clk_en;
  logic       slow_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_clk_pacer uut (
    .clk(clk), .rst_n(rst_n), .rst_evt(rst_evt),
    .slow_wr(slow_wr), .slow_val(slow_val),
    .swb_wr(swb_wr), .swb_val(swb_val),
    .irq_ack(irq_ack), .irq_en(irq_en),
    .ser_start(ser_start), .tx_load(tx_load),
    .clk_en(clk_en), .slow_mode(slow_mode)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Advance to the next falling edge and drop every strobe.
  task automatic step();
    @(negedge clk);
    rst_evt = 1'b0; slow_wr = 1'b0; swb_wr = 1'b0;
    irq_ack = 2'b00; ser_start = 1'b0; tx_load = 1'b0;
  endtask

  task automatic write_slow(input logic v);
    slow_wr = 1'b1; slow_val = v; step();
  endtask

  task automatic write_swb(input logic v);
    swb_wr = 1'b1; swb_val = v; step();
  endtask

  task automatic go_full();
    write_slow(1'b0);
  endtask

  task automatic t_reset();
    check("R1 slow_mode after reset", slow_mode, 0);
    check("R1 clk_en after reset", clk_en, 1);
  endtask

  task automatic t_enter_and_pace();
    int first = -1;
    int cnt = 0;
    write_slow(1'b1);
    check("R2 slow_mode after write", slow_mode, 1);
    if (clk_en) begin cnt++; first = 0; end
    for (int k = 1; k <= 600; k++) begin
      step();
      if (clk_en) begin
        cnt++;
        if (first < 0) first = k;
        if (k != 255 && k != 511) check("R3 pulse at unexpected cycle", k, 255);
      end
    end
    check("R3 first pulse position", first, 255);
    check("R3 pulse count in 601 cycles", cnt, 2);
  endtask

  task automatic t_exit_by_write();
    int lows = 0;
    go_full();
    check("R4 slow_mode after clear", slow_mode, 0);
    for (int k = 0; k < 20; k++) begin
      if (!clk_en) lows++;
      step();
    end
    check("R4 clk_en low cycles at full speed", lows, 0);
  endtask

  task automatic t_rewrite_keeps_phase();
    int first = -1;
    write_slow(1'b1);
    for (int k = 1; k <= 300; k++) begin
      if (k == 101) begin slow_wr = 1'b1; slow_val = 1'b1; end
      step();
      if (clk_en && first < 0) first = k;
    end
    check("R11 pulse phase after rewrite", first, 255);
    check("R11 still slow", slow_mode, 1);
    go_full();
  endtask

  task automatic t_switchback_events();
    write_swb(1'b1);
    for (int e = 0; e < 4; e++) begin
      write_slow(1'b1);
      repeat (5) step();
      check("R5 slow before event", slow_mode, 1);
      case (e)
        0: ser_start = 1'b1;
        1: tx_load = 1'b1;
        2: begin irq_en = 2'b01; irq_ack = 2'b01; end
        default: begin irq_en = 2'b10; irq_ack = 2'b10; end
      endcase
      step();
      check("R5 slow_mode after event", slow_mode, 0);
      check("R5 clk_en after event", clk_en, 1);
      irq_en = 2'b00;
    end
    // R8: more events and a long wait keep full speed
    for (int k = 0; k < 300; k++) begin
      tx_load = (k % 7 == 0);
      step();
      if (slow_mode) begin check("R8 left full speed", slow_mode, 0); break; end
    end
    check("R8 full speed held", slow_mode, 0);
    write_slow(1'b1);
    ser_start = 1'b1; step();
    check("R8 arm bit kept after switchback", slow_mode, 0);
  endtask

  task automatic t_irq_gating();
    write_slow(1'b1);
    irq_en = 2'b00; irq_ack = 2'b01; step();
    check("R6 ack without enable", slow_mode, 1);
    irq_en = 2'b01; irq_ack = 2'b00; step();
    step();
    check("R6 enable without ack", slow_mode, 1);
    irq_en = 2'b01; irq_ack = 2'b10; step();
    check("R6 ack and enable on different lines", slow_mode, 1);
    irq_en = 2'b00;
    go_full();
  endtask

  task automatic t_swb_off();
    write_swb(1'b0);
    write_slow(1'b1);
    ser_start = 1'b1; tx_load = 1'b1; irq_en = 2'b11; irq_ack = 2'b11;
    step();
    irq_en = 2'b00;
    step();
    check("R7 slow kept with switchback off", slow_mode, 1);
    go_full();
  endtask

  task automatic t_rst_evt();
    write_swb(1'b1);
    write_slow(1'b1);
    rst_evt = 1'b1; step();
    check("R9 slow_mode after reset request", slow_mode, 0);
    check("R9 clk_en after reset request", clk_en, 1);
    write_slow(1'b1);
    ser_start = 1'b1; step();
    check("R9 switchback disarmed by reset request", slow_mode, 1);
    go_full();
  endtask

  task automatic t_collision();
    write_swb(1'b1);
    slow_wr = 1'b1; slow_val = 1'b1; tx_load = 1'b1; step();
    check("R10 event beats slow write", slow_mode, 0);
    check("R10 clk_en stays high", clk_en, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_enter_and_pace();
    t_exit_by_write();
    t_rewrite_keeps_phase();
    t_switchback_events();
    t_irq_gating();
    t_swb_off();
    t_rst_evt();
    t_collision();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      finish_run();
    end
  end

endmodule